// File: doc/BRIEF.md
# MSI capability and message generator

This block holds the register set of a message-signalled interrupt capability and turns vector requests into memory-write messages. Software programs a target address, a 16-bit data pattern, how many vectors it enables and, when the option is built in, a mask bit per vector. It does this through a small configuration port that takes dword-wide reads and writes with byte enables. Device logic raises a vector with a one-cycle strobe. The block then emits a message that carries a 64-bit address and 32-bit data over a valid/ready handshake.

A vector whose mask bit is set does not produce a message. Its pending bit is set, and the message goes out later, once a write to the control word or the mask register leaves the vector unmasked. A write of that kind, made while the capability is enabled, also produces a one-cycle pulse that tells the legacy pin-based interrupt logic to drop its requests. The same write drops pending state for vectors that are no longer enabled.

Top module: `msi_cap_gen`

## Requirements
- R1: After reset the enable bit, enabled-count field, both address registers, the data register, the mask and pending registers read zero. The control word reads 0x186 with default parameters. msg_valid, intx_deassert and vec_err are low.
- R2: The control word is at offset 0. Bit 0 is the enable bit and bits 6:4 hold the log2 of the enabled vector count; both are writable through byte enable 0. Bits 3:1 hold the log2 of the capable count, bit 7 reports 64-bit address support and bit 8 reports per-vector masking. These three fields are fixed by parameters and ignore writes.
- R3: The address low register is at offset 1 and its bits 1:0 always read zero. The address high register is at offset 2 and is fully writable only when 64-bit addressing is built in; otherwise it reads zero.
- R4: A message carries address {high, low}. Its data bits 31:16 are zero. Its data bits 15:0 are the data register (offset 3), except that the low log2(enabled count) bits are replaced by the vector number.
- R5: The mask register is at offset 4 and the pending register at offset 5. Only mask bits below the capable count are writable, and the pending register is read-only. A request for a masked vector sends no message and sets its pending bit.
- R6: A control write whose enabled-count field exceeds the capable count stores the capable value.
- R7: One cycle after a write to offset 0 or offset 4 that leaves the enable bit set, intx_deassert is high for one cycle.
- R8: Such a write also clears pending bits for vectors at or above the enabled count.
- R9: Pending vectors that are unmasked while enabled are sent in ascending vector order. Each pending bit is cleared as its message is issued.
- R10: A request while the enable bit is clear, or with a vector number at or above the enabled count, is ignored and sets vec_err. vec_err stays set until reset.
- R11: Only one message is outstanding at a time. A message held with msg_ready low keeps its address and data. A pending unmasked vector is issued before any queued new request. Repeated requests for one vector that has not yet been issued merge into one message.
- R12: Reads of offsets 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Dword offset for read and write |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| vec_req | input | 1 | Vector request strobe |
| vec_num | input | 5 | Requested vector number |
| msg_valid | output | 1 | Message present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| intx_deassert | output | 1 | Pulse: drop legacy pin interrupts |
| vec_err | output | 1 | Sticky flag for an ignored request |

## Verification
The vector table sweeps the enabled count from one to eight vectors. It pairs each count with data patterns of all zeros, all ones and mixed bits, so the checks show whether exactly log2(count) low bits take the vector number and the bits above them keep the data register. The directed sequences raise vectors out of numeric order while they are masked, then unmask them together. This separates ascending replay from arrival order. A held message with a queued request and a pending vector both waiting shows whether replay takes priority. Shrinking the enabled count with high-numbered vectors pending shows whether those vectors are discarded rather than sent.

// File: rtl/msi_pkg.sv
package msi_pkg;
   localparam logic [2:0] OFS_CTRL = 3'd0;
   localparam logic [2:0] OFS_ALO  = 3'd1;
   localparam logic [2:0] OFS_AHI  = 3'd2;
   localparam logic [2:0] OFS_DATA = 3'd3;
   localparam logic [2:0] OFS_MASK = 3'd4;
   localparam logic [2:0] OFS_PEND = 3'd5;

   localparam int CTL_EN   = 0;
   localparam int CTL_CAP  = 1;
   localparam int CTL_ENL  = 4;
   localparam int CTL_A64  = 7;
   localparam int CTL_PVM  = 8;

   function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                            input logic [31:0] new_v,
                                            input logic [3:0]  be);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[b*8 +: 8] = be[b] ? new_v[b*8 +: 8] : old_v[b*8 +: 8];
      return r;
   endfunction

   function automatic logic [4:0] lowest_set(input logic [31:0] v);
      logic [4:0] r;
      r = '0;
      for (int i = 31; i >= 0; i--)
         if (v[i]) r = 5'(i);
      return r;
   endfunction
endpackage

// File: rtl/msi_cfg_regs.sv
module msi_cfg_regs import msi_pkg::*; #(
   parameter int VEC_LOG2_CAP = 3,
   parameter bit ADDR64       = 1'b1,
   parameter bit PER_VEC_MASK = 1'b1,
   localparam int NV = 1 << VEC_LOG2_CAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [2:0]    cfg_addr,
   input  logic [3:0]    cfg_be,
   input  logic [31:0]   cfg_wdata,
   output logic [31:0]   cfg_rdata,
   input  logic [NV-1:0] pend_in,
   output logic          en_q,
   output logic [2:0]    en_log2_q,
   output logic [63:0]   addr_q,
   output logic [15:0]   data_q,
   output logic [NV-1:0] mask_q,
   output logic          trig_q
);
   localparam logic [2:0] CAP3 = 3'(VEC_LOG2_CAP);

   logic [31:0] alo_q, ahi_q;
   logic        ctl_hit, next_en;
   logic [2:0]  enl_w;

   assign ctl_hit = cfg_wr && (cfg_addr == OFS_CTRL);
   assign next_en = (ctl_hit && cfg_be[0]) ? cfg_wdata[CTL_EN] : en_q;
   assign enl_w   = (cfg_wdata[CTL_ENL +: 3] > CAP3) ? CAP3 : cfg_wdata[CTL_ENL +: 3];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         en_log2_q <= '0;
         alo_q     <= '0;
         data_q    <= '0;
         trig_q    <= 1'b0;
      end else begin
         if (ctl_hit && cfg_be[0]) begin
            en_q      <= cfg_wdata[CTL_EN];
            en_log2_q <= enl_w;
         end
         if (cfg_wr && cfg_addr == OFS_ALO)
            alo_q <= be_merge(alo_q, cfg_wdata, cfg_be) & ~32'h3;
         if (cfg_wr && cfg_addr == OFS_DATA)
            data_q <= be_merge({16'h0, data_q}, cfg_wdata, cfg_be) [15:0];
         trig_q <= next_en && (ctl_hit ||
                   (PER_VEC_MASK && cfg_wr && cfg_addr == OFS_MASK));
      end
   end

   generate
      if (ADDR64) begin : g_ahi
         always_ff @(posedge clk) begin
            if (!rst_n) ahi_q <= '0;
            else if (cfg_wr && cfg_addr == OFS_AHI)
               ahi_q <= be_merge(ahi_q, cfg_wdata, cfg_be);
         end
      end else begin : g_no_ahi
         assign ahi_q = '0;
      end

      if (PER_VEC_MASK) begin : g_mask
         logic [31:0] mask32;
         always_comb begin
            mask32 = '0;
            mask32[NV-1:0] = mask_q;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) mask_q <= '0;
            else if (cfg_wr && cfg_addr == OFS_MASK)
               mask_q <= be_merge(mask32, cfg_wdata, cfg_be) [NV-1:0];
         end
      end else begin : g_no_mask
         assign mask_q = '0;
      end
   endgenerate

   assign addr_q = {ahi_q, alo_q};

   always_comb begin
      logic [31:0] ctl, m32, p32;
      ctl = '0;
      ctl[CTL_EN]         = en_q;
      ctl[CTL_CAP +: 3]   = CAP3;
      ctl[CTL_ENL +: 3]   = en_log2_q;
      ctl[CTL_A64]        = ADDR64;
      ctl[CTL_PVM]        = PER_VEC_MASK;
      m32 = '0;
      m32[NV-1:0] = mask_q;
      p32 = '0;
      p32[NV-1:0] = pend_in;
      case (cfg_addr)
         OFS_CTRL: cfg_rdata = ctl;
         OFS_ALO:  cfg_rdata = alo_q;
         OFS_AHI:  cfg_rdata = ahi_q;
         OFS_DATA: cfg_rdata = {16'h0, data_q};
         OFS_MASK: cfg_rdata = m32;
         OFS_PEND: cfg_rdata = p32;
         default:  cfg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/msi_vec_track.sv
module msi_vec_track import msi_pkg::*; #(
   parameter int VEC_LOG2_CAP = 3,
   localparam int NV = 1 << VEC_LOG2_CAP
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [2:0]    en_log2,
   input  logic [NV-1:0] mask,
   input  logic          trig,
   input  logic          req,
   input  logic [4:0]    req_num,
   input  logic          take,
   output logic [NV-1:0] pend_q,
   output logic          sel_valid,
   output logic [4:0]    sel_vec,
   output logic          err_q
);
   logic [NV-1:0] queue_q, range_m, pend_c, queue_c, rp_cand, rq_cand;
   logic [NV-1:0] pend_n, queue_n, req_oh;
   logic [31:0]   mask32, oh32, pick32;
   logic [5:0]    cnt;
   logic          good, from_pend;

   assign cnt = 6'd1 << en_log2;

   always_comb begin
      for (int i = 0; i < NV; i++) range_m[i] = (6'(i) < cnt);
      mask32 = '0;
      mask32[NV-1:0] = mask;
      oh32   = 32'd1 << req_num;
      req_oh = oh32[NV-1:0];
      good   = req && en && ({1'b0, req_num} < cnt);

      pend_c  = trig ? (pend_q & range_m) : pend_q;
      queue_c = trig ? (queue_q & range_m) : queue_q;
      pend_c  = pend_c | (queue_c & mask);
      queue_c = queue_c & ~mask;

      rp_cand   = pend_c & ~mask & range_m;
      rq_cand   = queue_c & range_m;
      from_pend = |rp_cand;
      sel_valid = en && (from_pend || (|rq_cand));
      pick32 = '0;
      pick32[NV-1:0] = from_pend ? rp_cand : rq_cand;
      sel_vec = lowest_set(pick32);

      pend_n  = pend_c;
      queue_n = queue_c;
      if (take && sel_valid) begin
         if (from_pend) pend_n[sel_vec[VEC_LOG2_CAP > 0 ? VEC_LOG2_CAP-1 : 0 : 0]] = 1'b0;
         else           queue_n[sel_vec[VEC_LOG2_CAP > 0 ? VEC_LOG2_CAP-1 : 0 : 0]] = 1'b0;
      end
      if (good) begin
         if (mask32[req_num]) pend_n  = pend_n | req_oh;
         else                 queue_n = queue_n | req_oh;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         queue_q <= '0;
         err_q   <= 1'b0;
      end else begin
         pend_q  <= pend_n;
         queue_q <= queue_n;
         if (req && !good) err_q <= 1'b1;
      end
   end
endmodule

// File: rtl/msi_msg_out.sv
module msi_msg_out (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sel_valid,
   input  logic [4:0]  sel_vec,
   input  logic [63:0] addr_q,
   input  logic [15:0] data_q,
   input  logic [2:0]  en_log2,
   input  logic        ready,
   output logic        take,
   output logic        valid_q,
   output logic [63:0] addr_o,
   output logic [31:0] data_o
);
   logic [15:0] low_m, merged;

   assign take   = !valid_q || ready;
   assign low_m  = 16'((17'd1 << en_log2) - 17'd1);
   assign merged = (data_q & ~low_m) | ({11'h0, sel_vec} & low_m);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else if (take) begin
         valid_q <= sel_valid;
         if (sel_valid) begin
            addr_o <= addr_q;
            data_o <= {16'h0, merged};
         end
      end
   end
endmodule

// File: rtl/msi_cap_gen.sv
module msi_cap_gen #(
   parameter int VEC_LOG2_CAP = 3,
   parameter bit ADDR64       = 1'b1,
   parameter bit PER_VEC_MASK = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_wr,
   input  logic [2:0]  cfg_addr,
   input  logic [3:0]  cfg_be,
   input  logic [31:0] cfg_wdata,
   output logic [31:0] cfg_rdata,
   input  logic        vec_req,
   input  logic [4:0]  vec_num,
   output logic        msg_valid,
   input  logic        msg_ready,
   output logic [63:0] msg_addr,
   output logic [31:0] msg_data,
   output logic        intx_deassert,
   output logic        vec_err
);
   localparam int NV = 1 << VEC_LOG2_CAP;

   generate
      if (VEC_LOG2_CAP < 0 || VEC_LOG2_CAP > 5) begin : g_bad_cap
         $error("VEC_LOG2_CAP must lie in 0..5");
      end
   endgenerate

   logic          ctrl_en, trig, take, sel_valid;
   logic [2:0]    ctrl_enl;
   logic [63:0]   addr_q;
   logic [15:0]   data_q;
   logic [NV-1:0] mask_q, pend_q;
   logic [4:0]    sel_vec;

   msi_cfg_regs #(.VEC_LOG2_CAP(VEC_LOG2_CAP), .ADDR64(ADDR64),
                  .PER_VEC_MASK(PER_VEC_MASK)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .pend_in(pend_q), .en_q(ctrl_en), .en_log2_q(ctrl_enl),
      .addr_q(addr_q), .data_q(data_q), .mask_q(mask_q), .trig_q(trig));

   msi_vec_track #(.VEC_LOG2_CAP(VEC_LOG2_CAP)) u_track (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en), .en_log2(ctrl_enl),
      .mask(mask_q), .trig(trig), .req(vec_req), .req_num(vec_num),
      .take(take), .pend_q(pend_q), .sel_valid(sel_valid),
      .sel_vec(sel_vec), .err_q(vec_err));

   msi_msg_out u_out (
      .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_vec(sel_vec),
      .addr_q(addr_q), .data_q(data_q), .en_log2(ctrl_enl),
      .ready(msg_ready), .take(take), .valid_q(msg_valid),
      .addr_o(msg_addr), .data_o(msg_data));

   assign intx_deassert = trig;
endmodule

// File: rtl/msi_cap_gen_chk.sv
module msi_cap_gen_chk #(
   parameter int CAP = 3
) (
   input logic        clk,
   input logic        rst_n,
   input logic        msg_valid,
   input logic        msg_ready,
   input logic [63:0] msg_addr,
   input logic [31:0] msg_data,
   input logic        vec_err,
   input logic        en,
   input logic [2:0]  en_log2
);
   assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_addr[1:0] == 2'b00);

   assert_data_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> msg_data[31:16] == 16'h0);

   assert_count_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(en_log2) <= CAP);

   assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      vec_err |=> vec_err);

   assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   assert_issue_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(en));
endmodule

bind msi_cap_gen msi_cap_gen_chk #(.CAP(VEC_LOG2_CAP)) u_chk (
   .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
   .msg_addr(msg_addr), .msg_data(msg_data), .vec_err(vec_err),
   .en(ctrl_en), .en_log2(ctrl_enl));

// File: tb/msi_cap_gen_tb.sv
module msi_cap_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        vec_req = 1'b0;
   logic [4:0]  vec_num = '0;
   logic        msg_valid, intx_deassert, vec_err;
   logic        msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   msi_cap_gen u_dut (.*);

   typedef struct packed {
      logic [2:0]  lg;
      logic [15:0] dat;
      logic [4:0]  vec;
      logic [15:0] exp;
   } row_t;

   localparam row_t TBL [6] = '{
      '{3'd0, 16'hABCD, 5'd0, 16'hABCD},
      '{3'd1, 16'h1230, 5'd1, 16'h1231},
      '{3'd2, 16'h12F3, 5'd2, 16'h12F2},
      '{3'd3, 16'hFFFF, 5'd5, 16'hFFFD},
      '{3'd3, 16'h0000, 5'd7, 16'h0007},
      '{3'd2, 16'h5555, 5'd3, 16'h5557}
   };

   localparam logic [63:0] TGT = 64'h01234567_DEADBEEC;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic req(input logic [4:0] n);
      vec_req = 1'b1; vec_num = n;
      @(negedge clk);
      vec_req = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_msg(input string tag, input logic [63:0] ea, input logic [15:0] ed);
      bit seen = 1'b0;
      msg_ready = 1'b1;
      for (int i = 0; i < 20; i++) begin
         if (msg_valid) begin seen = 1'b1; break; end
         @(negedge clk);
      end
      chk({tag, " valid"}, 64'(seen), 64'd1);
      chk({tag, " addr"}, msg_addr, ea);
      chk({tag, " data"}, 64'(msg_data), {48'h0, ed});
      @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            nerr++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
         end
      end
   end

   initial begin
      logic [31:0] r;
      @(negedge clk);
      do_reset();

      // R1 reset state
      rd(3'd0, r); chk("R1 ctrl", 64'(r), 64'h186);
      rd(3'd1, r); chk("R1 alo", 64'(r), 0);
      rd(3'd2, r); chk("R1 ahi", 64'(r), 0);
      rd(3'd3, r); chk("R1 data", 64'(r), 0);
      rd(3'd4, r); chk("R1 mask", 64'(r), 0);
      rd(3'd5, r); chk("R1 pend", 64'(r), 0);
      chk("R1 outputs", {61'h0, msg_valid, intx_deassert, vec_err}, 0);

      // R12 unimplemented offsets
      rd(3'd6, r); chk("R12 ofs6", 64'(r), 0);
      rd(3'd7, r); chk("R12 ofs7", 64'(r), 0);

      // R10 request while disabled
      req(5'd0);
      chk("R10 disabled err", 64'(vec_err), 1);
      repeat (3) @(negedge clk);
      chk("R10 disabled no msg", 64'(msg_valid), 0);
      do_reset();

      // R2 / R6 control field behaviour
      wr(3'd0, 32'hFFFF_FFFF, 4'hF);
      rd(3'd0, r); chk("R6 clamp and R2 ro bits", 64'(r), 64'h1B7);
      wr(3'd0, 32'h0, 4'hE);
      rd(3'd0, r); chk("R2 be0 clear keeps ctrl", 64'(r), 64'h1B7);
      wr(3'd0, 32'h0, 4'h1);
      rd(3'd0, r); chk("R2 ctrl cleared", 64'(r), 64'h186);

      // R3 address registers
      wr(3'd1, 32'hDEADBEEF, 4'hF);
      wr(3'd2, 32'h01234567, 4'hF);
      rd(3'd1, r); chk("R3 alo low bits zero", 64'(r), 64'hDEADBEEC);
      rd(3'd2, r); chk("R3 ahi", 64'(r), 64'h01234567);

      // R4 message content table
      foreach (TBL[i]) begin
         wr(3'd0, 32'((TBL[i].lg << 4) | 1), 4'h1);
         wr(3'd3, {16'h0, TBL[i].dat}, 4'hF);
         req(TBL[i].vec);
         wait_msg($sformatf("R4 row%0d", i), TGT, TBL[i].exp);
      end
      chk("R10 no err after legal reqs", 64'(vec_err), 0);

      // R5 mask and pending
      wr(3'd0, 32'h31, 4'h1);
      wr(3'd3, 32'h1000, 4'hF);
      wr(3'd4, 32'hFFFF_FFFF, 4'hF);
      rd(3'd4, r); chk("R5 mask only implemented", 64'(r), 64'hFF);
      wr(3'd4, 32'h20, 4'hF);
      req(5'd5);
      repeat (3) @(negedge clk);
      chk("R5 masked no msg", 64'(msg_valid), 0);
      rd(3'd5, r); chk("R5 pending set", 64'(r), 64'h20);
      wr(3'd5, 32'h0, 4'hF);
      rd(3'd5, r); chk("R5 pending read-only", 64'(r), 64'h20);
      wr(3'd4, 32'h0, 4'hF);
      chk("R7 intx pulse", 64'(intx_deassert), 1);
      wait_msg("R9 single replay", TGT, 16'h1005);
      rd(3'd5, r); chk("R9 pending cleared", 64'(r), 0);

      // R9 ascending replay with held first message (R11)
      wr(3'd4, 32'hFF, 4'hF);
      req(5'd6); req(5'd2); req(5'd4);
      rd(3'd5, r); chk("R5 three pending", 64'(r), 64'h54);
      msg_ready = 1'b0;
      wr(3'd4, 32'h0, 4'hF);
      repeat (4) @(negedge clk);
      chk("R11 held valid", 64'(msg_valid), 1);
      chk("R11 held data", 64'(msg_data), 64'h1002);
      wait_msg("R9 first", TGT, 16'h1002);
      wait_msg("R9 second", TGT, 16'h1004);
      wait_msg("R9 third", TGT, 16'h1006);

      // R11 replay before queued request
      wr(3'd4, 32'h10, 4'hF);
      req(5'd4);
      msg_ready = 1'b0;
      req(5'd0);
      req(5'd1);
      req(5'd1);
      wr(3'd4, 32'h0, 4'hF);
      @(negedge clk);
      wait_msg("R11 held vec0", TGT, 16'h1000);
      wait_msg("R11 replay first", TGT, 16'h1004);
      wait_msg("R11 queued after", TGT, 16'h1001);
      repeat (3) @(negedge clk);
      chk("R11 merged repeat", 64'(msg_valid), 0);

      // R8 discard above shrunk count
      do_reset();
      wr(3'd0, 32'h31, 4'h1);
      wr(3'd3, 32'h4440, 4'hF);
      wr(3'd4, 32'hFF, 4'hF);
      req(5'd7); req(5'd1);
      rd(3'd5, r); chk("R8 before shrink", 64'(r), 64'h82);
      wr(3'd0, 32'h11, 4'h1);
      chk("R7 intx on ctrl write", 64'(intx_deassert), 1);
      @(negedge clk);
      chk("R7 intx one cycle", 64'(intx_deassert), 0);
      rd(3'd5, r); chk("R8 discarded", 64'(r), 64'h02);
      wr(3'd4, 32'h0, 4'hF);
      wait_msg("R8 survivor", 64'h0, 16'h4441);

      // R10 out-of-range request
      chk("R10 err clear", 64'(vec_err), 0);
      req(5'd3);
      chk("R10 range err", 64'(vec_err), 1);
      repeat (3) @(negedge clk);
      chk("R10 no msg", 64'(msg_valid), 0);
      chk("R10 err sticky", 64'(vec_err), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule